// File: doc/BRIEF.md
# Four-Channel Capture/Compare Output Controller

The block holds a 16-bit control word that configures four capture/compare channels. Each channel has its own 16-bit value register. In capture mode, a rising edge on the channel's asynchronous input stores the current count of the channel's timebase in that register. In compare mode, the channel flags every cycle in which the timebase count equals the stored value, and it produces a pulse-width signal that starts at the counter wrap and ends at the match. Each channel drives one output pin. The pin either follows that generated signal with a programmable polarity, or is parked at the inactive level of that polarity.

Channels 0 and 1 follow timebase 0, and channels 2 and 3 follow timebase 1. The timebase counters, their run flags and the global power flag come from outside the block. The control word is written through a per-bit write mask, so a word, either byte, or a single bit can be updated in one access. While the unit is powered, the mode bits are frozen. While the unit is powered and a channel's timebase is running, that channel's polarity bit is also frozen.

Top module: `tmr_cc_unit`

## Requirements
- R1: After reset the control word reads 0x4444, every value register reads 0, every interrupt is 0 and every pin is 0.
- R2: Channel k owns control bits 4k+3..4k: bit 4k+3 is output enable, bit 4k+2 is active level (1 = active high), bit 4k+1 is mode (1 = compare, 0 = capture), and bit 4k is reserved and always reads 0.
- R3: A write changes exactly the control bits whose `ctl_wr_mask` bit is 1, taking them from `ctl_wr_data`, and the result is visible on `ctl_rd` after the next clock edge.
- R4: While `power_on` is 1, writes leave every mode bit unchanged.
- R5: While `power_on` and the run flag of the channel's timebase are both 1, writes leave that channel's active-level bit unchanged. Channels 0 and 1 use `tb_run[0]`; channels 2 and 3 use `tb_run[1]`.
- R6: Enable bits are always writable, and active-level bits are writable whenever `power_on` is 0, regardless of `tb_run`.
- R7: A channel with enable 0 drives its pin to the inverse of its active-level bit.
- R8: In capture mode, a 0-to-1 change of `cap_in[k]` first sampled at clock edge n loads the timebase count present at edge n+2 into value register k and raises `cc_irq[k]` for exactly the one cycle after edge n+2. A capture takes priority over a software load in the same cycle.
- R9: In compare mode, `cc_irq[k]` is 1 for the cycle after each clock edge at which the timebase count equals value register k. Capture-mode edges do not raise it in compare mode.
- R10: In compare mode, the generated signal becomes active after an edge where the count is 0 and inactive after an edge where the count matches; a match wins when both hold. In capture mode it is inactive. An enabled pin shows the active level while the generated signal is active, and the inverse level otherwise.
- R11: `cc_wr_en` with `cc_wr_sel` = k loads `cc_wr_data` into value register k at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr_en | input | 1 | Control word write strobe |
| ctl_wr_mask | input | 16 | Per-bit write enable for the control word |
| ctl_wr_data | input | 16 | Control write data |
| ctl_rd | output | 16 | Current control word |
| power_on | input | 1 | Global power flag (locks mode bits) |
| tb_run | input | 2 | Run flags of timebase 0 and 1 |
| tb_cnt | input | 32 | Timebase counts, timebase 1 in the upper half |
| cc_wr_en | input | 1 | Value register load strobe |
| cc_wr_sel | input | 2 | Channel selected for load |
| cc_wr_data | input | 16 | Value to load |
| cc_val | output | 64 | Value registers, channel k at bits 16k+15..16k |
| cap_in | input | 4 | Asynchronous capture inputs |
| cc_irq | output | 4 | Per-channel one-cycle interrupt |
| pin_out | output | 4 | Channel output pins |

## Verification
Control writes and value loads appear one edge after they are sampled. Compare interrupts and changes of the generated signal appear one edge after the count that triggers them, so the pin moves in the same cycle as the signal. A capture lands two edges after the input change is first sampled: the value and the interrupt are both registered at edge n+2. The bench drives inputs on the falling edge and steps a reference model on the rising edge, using the inputs held at that edge. It compares every output at the next falling edge, which keeps each expected value aligned with its register delay.

// File: rtl/tmr_cc_pkg.sv
package tmr_cc_pkg;
    localparam int NIB_W   = 4;
    localparam int EN_BIT  = 3;
    localparam int ALV_BIT = 2;
    localparam int SEL_BIT = 1;
    localparam int RSV_BIT = 0;
    localparam logic [NIB_W-1:0] NIB_RST = 4'h4;
endpackage

// File: rtl/tmr_cc_ctrl_reg.sv
module tmr_cc_ctrl_reg
    import tmr_cc_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int CH_PER_TB = 2,
    localparam int W        = NUM_CH * NIB_W,
    localparam int NUM_TB   = NUM_CH / CH_PER_TB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [W-1:0]      wr_mask,
    input  logic [W-1:0]      wr_data,
    input  logic              power_on,
    input  logic [NUM_TB-1:0] tb_run,
    output logic [W-1:0]      ctrl_q
);
    typedef struct packed {
        logic [W-1:0] word;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;
    logic [W-1:0] rst_word;
    logic [W-1:0] eff_mask;

    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            rst_word[c*NIB_W +: NIB_W] = NIB_RST;
        end
    end

    always_comb begin
        eff_mask = wr_en ? wr_mask : '0;
        for (int c = 0; c < NUM_CH; c++) begin
            eff_mask[c*NIB_W + RSV_BIT] = 1'b0;
            if (power_on) begin
                eff_mask[c*NIB_W + SEL_BIT] = 1'b0;
                if (tb_run[c / CH_PER_TB]) begin
                    eff_mask[c*NIB_W + ALV_BIT] = 1'b0;
                end
            end
        end
        st_d.word = (st_q.word & ~eff_mask) | (wr_data & eff_mask);
        for (int c = 0; c < NUM_CH; c++) begin
            st_d.word[c*NIB_W + RSV_BIT] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.word <= rst_word;
        else        st_q      <= st_d;
    end

    assign ctrl_q = st_q.word;
endmodule

// File: rtl/tmr_cc_sync.sv
module tmr_cc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    typedef struct packed {
        logic [STAGES:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d.chain = {st_q.chain[STAGES-1:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise = st_q.chain[STAGES-1] & ~st_q.chain[STAGES];
endmodule

// File: rtl/tmr_cc_chan.sv
module tmr_cc_chan #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_rise,
    input  logic [CNT_W-1:0] cnt,
    input  logic             out_en,
    input  logic             act_hi,
    input  logic             cmp_mode,
    input  logic             ld_en,
    input  logic [CNT_W-1:0] ld_data,
    output logic [CNT_W-1:0] val_o,
    output logic             irq_o,
    output logic             pin_o
);
    typedef struct packed {
        logic [CNT_W-1:0] val;
        logic             irq;
        logic             gen;
    } chan_state_t;

    chan_state_t st_d, st_q;
    logic take_cap;
    logic hit;

    always_comb begin
        take_cap = !cmp_mode && cap_rise;
        hit      = cmp_mode && (st_q.val == cnt);
        st_d     = st_q;
        if (take_cap)   st_d.val = cnt;
        else if (ld_en) st_d.val = ld_data;
        st_d.irq = take_cap || hit;
        if (!cmp_mode)              st_d.gen = 1'b0;
        else if (hit)               st_d.gen = 1'b0;
        else if (cnt == '0)         st_d.gen = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign val_o = st_q.val;
    assign irq_o = st_q.irq;
    assign pin_o = out_en ? (st_q.gen ? act_hi : ~act_hi) : ~act_hi;
endmodule

// File: rtl/tmr_cc_unit.sv
module tmr_cc_unit
    import tmr_cc_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int CH_PER_TB   = 2,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             ctl_wr_en,
    input  logic [NUM_CH*4-1:0]              ctl_wr_mask,
    input  logic [NUM_CH*4-1:0]              ctl_wr_data,
    output logic [NUM_CH*4-1:0]              ctl_rd,
    input  logic                             power_on,
    input  logic [NUM_CH/CH_PER_TB-1:0]      tb_run,
    input  logic [NUM_CH/CH_PER_TB*CNT_W-1:0] tb_cnt,
    input  logic                             cc_wr_en,
    input  logic [$clog2(NUM_CH)-1:0]        cc_wr_sel,
    input  logic [CNT_W-1:0]                 cc_wr_data,
    output logic [NUM_CH*CNT_W-1:0]          cc_val,
    input  logic [NUM_CH-1:0]                cap_in,
    output logic [NUM_CH-1:0]                cc_irq,
    output logic [NUM_CH-1:0]                pin_out
);
    localparam int SEL_W = $clog2(NUM_CH);

    logic [NUM_CH*NIB_W-1:0] ctl_q;
    logic [NUM_CH-1:0]       cap_rise;

    tmr_cc_ctrl_reg #(
        .NUM_CH   (NUM_CH),
        .CH_PER_TB(CH_PER_TB)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ctl_wr_en),
        .wr_mask (ctl_wr_mask),
        .wr_data (ctl_wr_data),
        .power_on(power_on),
        .tb_run  (tb_run),
        .ctrl_q  (ctl_q)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam int TB = i / CH_PER_TB;

        tmr_cc_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (cap_in[i]),
            .rise (cap_rise[i])
        );

        tmr_cc_chan #(.CNT_W(CNT_W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .cap_rise(cap_rise[i]),
            .cnt     (tb_cnt[TB*CNT_W +: CNT_W]),
            .out_en  (ctl_q[i*NIB_W + EN_BIT]),
            .act_hi  (ctl_q[i*NIB_W + ALV_BIT]),
            .cmp_mode(ctl_q[i*NIB_W + SEL_BIT]),
            .ld_en   (cc_wr_en && (cc_wr_sel == SEL_W'(i))),
            .ld_data (cc_wr_data),
            .val_o   (cc_val[i*CNT_W +: CNT_W]),
            .irq_o   (cc_irq[i]),
            .pin_o   (pin_out[i])
        );
    end

    assign ctl_rd = ctl_q;
endmodule

// File: rtl/tmr_cc_unit_chk.sv
module tmr_cc_unit_chk #(
    parameter int NUM_CH      = 4,
    parameter int CH_PER_TB   = 2,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic [NUM_CH*4-1:0]               ctl_rd,
    input logic                              power_on,
    input logic [NUM_CH/CH_PER_TB-1:0]       tb_run,
    input logic [NUM_CH/CH_PER_TB*CNT_W-1:0] tb_cnt,
    input logic [NUM_CH*CNT_W-1:0]           cc_val,
    input logic [NUM_CH-1:0]                 cc_irq,
    input logic [NUM_CH-1:0]                 pin_out
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        localparam int TB = i / CH_PER_TB;

        assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
            ctl_rd[4*i] == 1'b0);

        assert_mode_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
            power_on |=> $stable(ctl_rd[4*i+1]));

        assert_level_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (power_on && tb_run[TB]) |=> $stable(ctl_rd[4*i+2]));

        assert_idle_pin_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !ctl_rd[4*i+3] |-> (pin_out[i] == !ctl_rd[4*i+2]));

        assert_cap_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(!ctl_rd[4*i+1]) && cc_irq[i])
            |-> (cc_val[i*CNT_W +: CNT_W] == $past(tb_cnt[TB*CNT_W +: CNT_W])));

        assert_cmp_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(ctl_rd[4*i+1])
             && $past(cc_val[i*CNT_W +: CNT_W] == tb_cnt[TB*CNT_W +: CNT_W]))
            |-> cc_irq[i]);
    end
endmodule

bind tmr_cc_unit tmr_cc_unit_chk #(
    .NUM_CH     (NUM_CH),
    .CH_PER_TB  (CH_PER_TB),
    .CNT_W      (CNT_W),
    .SYNC_STAGES(SYNC_STAGES)
) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl_rd  (ctl_rd),
    .power_on(power_on),
    .tb_run  (tb_run),
    .tb_cnt  (tb_cnt),
    .cc_val  (cc_val),
    .cc_irq  (cc_irq),
    .pin_out (pin_out)
);

// File: tb/test_tmr_cc_unit.sv
module test_tmr_cc_unit;
    localparam int CLK_PERIOD = 10;
    localparam int PER0 = 20;
    localparam int PER1 = 13;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr_en = 1'b0;
    logic [15:0] ctl_wr_mask = '0;
    logic [15:0] ctl_wr_data = '0;
    logic [15:0] ctl_rd;
    logic        power_on = 1'b0;
    logic [1:0]  tb_run = '0;
    logic [31:0] tb_cnt = '0;
    logic        cc_wr_en = 1'b0;
    logic [1:0]  cc_wr_sel = '0;
    logic [15:0] cc_wr_data = '0;
    logic [63:0] cc_val;
    logic [3:0]  cap_in = '0;
    logic [3:0]  cc_irq;
    logic [3:0]  pin_out;

    int n_checks = 0;
    int n_fails = 0;
    bit finished = 0;

    logic [15:0] m_ctrl;
    logic [15:0] m_cc [4];
    logic [3:0]  m_irq, m_gen, m_s1, m_s2, m_s3;
    logic [15:0] edge_cnt0;
    int tb0 = 0, tb1 = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_cc_unit i_tmr_cc_unit (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr_en(ctl_wr_en), .ctl_wr_mask(ctl_wr_mask), .ctl_wr_data(ctl_wr_data),
        .ctl_rd(ctl_rd), .power_on(power_on), .tb_run(tb_run), .tb_cnt(tb_cnt),
        .cc_wr_en(cc_wr_en), .cc_wr_sel(cc_wr_sel), .cc_wr_data(cc_wr_data),
        .cc_val(cc_val), .cap_in(cap_in), .cc_irq(cc_irq), .pin_out(pin_out)
    );

    function automatic logic [15:0] apply_write(logic [15:0] cur, logic en, logic [15:0] msk,
                                                logic [15:0] dat, logic pwr, logic [1:0] run);
        logic [15:0] m = en ? msk : 16'h0;
        for (int c = 0; c < 4; c++) begin
            m[4*c] = 1'b0;
            if (pwr) begin
                m[4*c+1] = 1'b0;
                if (run[c/2]) m[4*c+2] = 1'b0;
            end
        end
        return (cur & ~m) | (dat & m);
    endfunction

    function automatic logic [3:0] expect_pins(logic [15:0] ctl, logic [3:0] gen);
        logic [3:0] p;
        for (int c = 0; c < 4; c++) begin
            p[c] = (ctl[4*c+3] && gen[c]) ? ctl[4*c+2] : !ctl[4*c+2];
        end
        return p;
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_step();
        logic [15:0] ncc [4];
        logic [3:0]  ni, ng;
        for (int c = 0; c < 4; c++) begin
            logic [15:0] cnt = (c < 2) ? tb_cnt[15:0] : tb_cnt[31:16];
            logic sel = m_ctrl[4*c+1];
            logic cap = !sel && m_s2[c] && !m_s3[c];
            logic mt  = sel && (m_cc[c] == cnt);
            ni[c] = cap || mt;
            ncc[c] = cap ? cnt : ((cc_wr_en && cc_wr_sel == 2'(c)) ? cc_wr_data : m_cc[c]);
            ng[c] = !sel ? 1'b0 : (mt ? 1'b0 : ((cnt == 16'h0) ? 1'b1 : m_gen[c]));
        end
        m_s3 = m_s2; m_s2 = m_s1; m_s1 = cap_in;
        m_ctrl = apply_write(m_ctrl, ctl_wr_en, ctl_wr_mask, ctl_wr_data, power_on, tb_run);
        for (int c = 0; c < 4; c++) m_cc[c] = ncc[c];
        m_irq = ni; m_gen = ng;
    endtask

    task automatic compare_all();
        check("R3 control word", 64'(ctl_rd), 64'(m_ctrl));
        for (int c = 0; c < 4; c++) check("R8 value reg", 64'(cc_val[16*c +: 16]), 64'(m_cc[c]));
        check("R9 irq", 64'(cc_irq), 64'(m_irq));
        check("R10 pins", 64'(pin_out), 64'(expect_pins(m_ctrl, m_gen)));
    endtask

    task automatic cycle();
        @(posedge clk);
        edge_cnt0 = tb_cnt[15:0];
        model_step();
        @(negedge clk);
        compare_all();
        tb0 = (tb0 == PER0 - 1) ? 0 : tb0 + 1;
        tb1 = (tb1 == PER1 - 1) ? 0 : tb1 + 1;
        tb_cnt = {16'(tb1), 16'(tb0)};
        ctl_wr_en = 1'b0;
        cc_wr_en = 1'b0;
    endtask

    task automatic ctl_write(logic [15:0] msk, logic [15:0] dat);
        ctl_wr_en = 1'b1; ctl_wr_mask = msk; ctl_wr_data = dat;
        cycle();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_ctrl = 16'h4444; m_irq = '0; m_gen = '0; m_s1 = '0; m_s2 = '0; m_s3 = '0;
        for (int c = 0; c < 4; c++) m_cc[c] = '0;
        check("R1 reset ctl", 64'(ctl_rd), 64'h4444);
        check("R1 reset values", cc_val, 64'h0);
        check("R1 reset irq", 64'(cc_irq), 64'h0);
        check("R1 reset pins", 64'(pin_out), 64'h0);

        // R8: capture latency and one-cycle pulse
        cap_in = 4'b0001;
        cycle(); check("R8 no irq yet", 64'(cc_irq[0]), 64'h0);
        cycle(); check("R8 no irq yet", 64'(cc_irq[0]), 64'h0);
        cycle(); check("R8 irq", 64'(cc_irq[0]), 64'h1);
        check("R8 captured count", 64'(cc_val[15:0]), 64'(edge_cnt0));
        cycle(); check("R8 pulse ends", 64'(cc_irq[0]), 64'h0);

        // R2 R3 field layout and masked writes
        ctl_write(16'hFFFF, 16'hFFFF); check("R2 reserved zero", 64'(ctl_rd), 64'hEEEE);
        ctl_write(16'h00FF, 16'h0000); check("R3 byte write", 64'(ctl_rd), 64'hEE00);
        ctl_write(16'h0008, 16'hFFFF); check("R3 bit write", 64'(ctl_rd), 64'hEE08);
        power_on = 1'b1; tb_run = 2'b00;
        ctl_write(16'hFFFF, 16'h0000); check("R4 mode lock", 64'(ctl_rd), 64'h2200);
        check("R7 idle pins", 64'(pin_out), 64'hF);
        tb_run = 2'b01;
        ctl_write(16'hFFFF, 16'hFFFF); check("R5 level lock", 64'(ctl_rd), 64'hEE88);
        power_on = 1'b0; tb_run = 2'b11;
        ctl_write(16'h0066, 16'hFFFF); check("R6 unlocked", 64'(ctl_rd), 64'hEEEE);
        tb_run = 2'b00;

        // R11 load and R9 R10 compare/PWM on channel 0
        cc_wr_en = 1'b1; cc_wr_sel = 2'd0; cc_wr_data = 16'd5;
        cycle(); check("R11 load", 64'(cc_val[15:0]), 64'd5);
        cc_wr_en = 1'b1; cc_wr_sel = 2'd2; cc_wr_data = 16'h1234;
        cycle(); check("R11 load ch2", 64'(cc_val[47:32]), 64'h1234);
        for (int k = 0; k < 60 && edge_cnt0 != 16'd0; k++) cycle();
        if (edge_cnt0 != 16'd0) cycle();
        check("R10 active after wrap", 64'(pin_out[0]), 64'h1);
        for (int k = 0; k < 60 && edge_cnt0 != 16'd5; k++) cycle();
        check("R10 inactive after match", 64'(pin_out[0]), 64'h0);
        check("R9 compare irq", 64'(cc_irq[0]), 64'h1);

        // random phase
        for (int n = 0; n < 4000; n++) begin
            if ($urandom % 8 == 0) begin
                ctl_wr_en = 1'b1;
                case ($urandom % 4)
                    0: ctl_wr_mask = 16'hFFFF;
                    1: ctl_wr_mask = 16'h00FF;
                    2: ctl_wr_mask = 16'hFF00;
                    default: ctl_wr_mask = 16'(1) << ($urandom % 16);
                endcase
                ctl_wr_data = 16'($urandom);
            end
            if ($urandom % 16 == 0) power_on = 1'($urandom);
            if ($urandom % 16 == 0) tb_run = 2'($urandom);
            if ($urandom % 4 == 0) cap_in = cap_in ^ 4'(1 << ($urandom % 4));
            if ($urandom % 10 == 0) begin
                cc_wr_en = 1'b1; cc_wr_sel = 2'($urandom); cc_wr_data = 16'($urandom % PER0);
            end
            cycle();
        end

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule